// File: doc/BRIEF.md
# Dual-Core MESI Coherent Cache Pair

Two private data caches, one for each of two cores, are kept coherent by a snooping MESI protocol and sit in front of a shared byte-addressed backing memory. The cores take turns. Each cycle, at most one byte read or byte write enters on a single request port, tagged with the core that issues it. The block then does the whole transaction at one clock edge: lookup, victim write-back, snoop of the other cache, fill and state update. It answers one cycle later with a hit flag and a data byte.

Each cache has 4 sets. Each set has two ways, and each way holds a 2-byte line, so a cache holds 16 bytes. Writes are write-back with write-allocate. A read miss takes ownership when no other copy exists and shares the line otherwise. A write claims the line exclusively and invalidates the peer copy. Dirty data leaves a cache when its line is evicted, and also when the peer snoops it. The states of all lines are exported as one flat vector, so a bench or a neighbouring block can watch the coherence state directly.

Top module: `mesi_cache_pair`

## Requirements
- R1: After reset every line of both caches reads Invalid (code 0) on `line_state`, `resp_valid` is 0, and memory byte i holds (7*i+1) mod 256.
- R2: Address bit 0 selects the byte within a line, bits 2:1 select the set, and the upper bits form the tag. Each set of each cache has two ways. The state of core c, set s, way w sits at bits [2*(8c+2s+w)+1 : 2*(8c+2s+w)] of `line_state`, encoded I=0, S=1, E=2, M=3.
- R3: A read miss whose line is held by neither cache fills from memory in state E and returns the memory byte.
- R4: A read miss whose line the peer holds fills in S and moves the peer copy to S. If the peer held it in M, the peer's bytes are supplied and also written to memory.
- R5: Every write leaves the writer's line in M. A write miss, or a write to an S line, sets the peer copy to I, and an M peer copy is written to memory first.
- R6: A write hit on an E line becomes M without changing any state of the peer cache.
- R7: The fill way is chosen as follows: the lowest never-filled way first, then the lowest way in state I, and otherwise the least recently used way.
- R8: When an M line is evicted, both of its bytes are written to memory before the new line fills. A later miss on that address returns the written data.
- R9: Every hit and every fill marks the other way of that set as least recently used.
- R10: `resp_valid` is high exactly one cycle after a request. `resp_hit` reports the lookup result. `resp_rdata` carries the read byte, or for a write the byte just written.
- R11: A line never sits in E or M in one cache while the other cache holds it in any valid state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_core | input | 1 | Issuing core (0 or 1) |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write byte |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_hit | output | 1 | The request hit in the issuer's cache |
| resp_rdata | output | DW | Read byte, or the written byte for writes |
| line_state | output | 8*2^SET_BITS | MESI state of every line of both caches |

## Verification
Two functions can fall in the same cycle. In one request, the requester evicts a dirty victim, and the snoop makes the peer give up its own dirty copy of the requested line. The bench provokes this as follows. One core fills both ways of a set with M lines, the other core writes a third line of that set, and the first core then reads that third line. The bench checks that the returned byte comes from the peer, that both copies end in S, and that a later miss from the peer on the evicted address returns the byte written before the eviction. A reference model in the bench also replays a mixed access table and compares hit, data and the full state vector after every access.

// File: rtl/mesi_cache_pair.sv
`timescale 1ns/1ps
module mesi_cache_pair #(
  parameter int AW       = 6,
  parameter int DW       = 8,
  parameter int SET_BITS = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic                        req_core,
  input  logic                        req_write,
  input  logic [AW-1:0]               req_addr,
  input  logic [DW-1:0]               req_wdata,
  output logic                        resp_valid,
  output logic                        resp_hit,
  output logic [DW-1:0]               resp_rdata,
  output logic [8*(1<<SET_BITS)-1:0]  line_state
);
  localparam int SETS = 1 << SET_BITS;
  localparam int TW   = AW - SET_BITS - 1;
  localparam int MEMN = 1 << AW;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;

  logic [1:0]    st    [2][SETS][2];
  logic          fld   [2][SETS][2];
  logic [TW-1:0] tg    [2][SETS][2];
  logic [DW-1:0] dat   [2][SETS][2][2];
  logic          lru   [2][SETS];
  logic [DW-1:0] mem   [MEMN];

  logic                c, o, b;
  logic [SET_BITS-1:0] s;
  logic [TW-1:0]       t;
  logic [1:0]          hv, ov;
  logic                hit, hw, ohit, ow, vw, way, peer_dirty;
  logic [DW-1:0]       fill [2];

  assign c = req_core;
  assign o = ~req_core;
  assign b = req_addr[0];
  assign s = req_addr[SET_BITS:1];
  assign t = req_addr[AW-1:SET_BITS+1];

  always_comb begin
    for (int w = 0; w < 2; w++) begin
      hv[w] = (st[c][s][w] != ST_I) && (tg[c][s][w] == t);
      ov[w] = (st[o][s][w] != ST_I) && (tg[o][s][w] == t);
    end
  end

  assign hit  = |hv;
  assign hw   = hv[1];
  assign ohit = |ov;
  assign ow   = ov[1];
  assign peer_dirty = ohit && (st[o][s][ow] == ST_M);
  assign way  = hit ? hw : vw;

  always_comb begin
    if (!fld[c][s][0])               vw = 1'b0;
    else if (!fld[c][s][1])          vw = 1'b1;
    else if (st[c][s][0] == ST_I)    vw = 1'b0;
    else if (st[c][s][1] == ST_I)    vw = 1'b1;
    else                             vw = lru[c][s];
  end

  always_comb begin
    for (int k = 0; k < 2; k++)
      fill[k] = peer_dirty ? dat[o][s][ow][k] : mem[{t, s, 1'(k)}];
  end

  logic                chk_vld_q, chk_wr_q, chk_miss_q;
  logic [SET_BITS+1:0] chk_idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_hit   <= 1'b0;
      resp_rdata <= '0;
      chk_vld_q  <= 1'b0;
      chk_wr_q   <= 1'b0;
      chk_miss_q <= 1'b0;
      chk_idx_q  <= '0;
      for (int cc = 0; cc < 2; cc++)
        for (int ss = 0; ss < SETS; ss++) begin
          lru[cc][ss] <= 1'b0;
          for (int ww = 0; ww < 2; ww++) begin
            st[cc][ss][ww]     <= ST_I;
            fld[cc][ss][ww]    <= 1'b0;
            tg[cc][ss][ww]     <= '0;
            dat[cc][ss][ww][0] <= '0;
            dat[cc][ss][ww][1] <= '0;
          end
        end
      for (int i = 0; i < MEMN; i++) mem[i] <= DW'(7 * i + 1);
    end else begin
      resp_valid <= req_valid;
      chk_vld_q  <= req_valid;
      chk_wr_q   <= req_write;
      chk_miss_q <= !hit;
      chk_idx_q  <= {c, s, way};
      if (req_valid) begin
        resp_hit   <= hit;
        lru[c][s]  <= ~way;
        if (hit) begin
          resp_rdata <= req_write ? req_wdata : dat[c][s][hw][b];
          if (req_write) begin
            dat[c][s][hw][b] <= req_wdata;
            st[c][s][hw]     <= ST_M;
            if (ohit) st[o][s][ow] <= ST_I;
          end
        end else begin
          if (st[c][s][vw] == ST_M)
            for (int k = 0; k < 2; k++) mem[{tg[c][s][vw], s, 1'(k)}] <= dat[c][s][vw][k];
          if (peer_dirty)
            for (int k = 0; k < 2; k++) mem[{t, s, 1'(k)}] <= dat[o][s][ow][k];
          if (ohit) st[o][s][ow] <= req_write ? ST_I : ST_S;
          for (int k = 0; k < 2; k++)
            dat[c][s][vw][k] <= (req_write && (1'(k) == b)) ? req_wdata : fill[k];
          tg[c][s][vw]  <= t;
          fld[c][s][vw] <= 1'b1;
          st[c][s][vw]  <= req_write ? ST_M : (ohit ? ST_S : ST_E);
          resp_rdata    <= req_write ? req_wdata : fill[b];
        end
      end
    end
  end

  for (genvar gc = 0; gc < 2; gc++) begin : g_core
    for (genvar gs = 0; gs < SETS; gs++) begin : g_set
      for (genvar gw = 0; gw < 2; gw++) begin : g_way
        assign line_state[2*(gc*SETS*2 + gs*2 + gw) +: 2] = st[gc][gs][gw];
      end
    end
  end

  logic owner_clash;
  always_comb begin
    owner_clash = 1'b0;
    for (int ss = 0; ss < SETS; ss++)
      for (int w0 = 0; w0 < 2; w0++)
        for (int w1 = 0; w1 < 2; w1++)
          if (st[0][ss][w0] != ST_I && st[1][ss][w1] != ST_I &&
              tg[0][ss][w0] == tg[1][ss][w1] &&
              (st[0][ss][w0][1] || st[1][ss][w1][1]))
            owner_clash = 1'b1;
  end

  // R11
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n) !owner_clash);
  // R10
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> resp_valid);
  // R10
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !resp_valid);
  // R5
  write_owns_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_vld_q && chk_wr_q) |-> (line_state[{chk_idx_q, 1'b0} +: 2] == ST_M));
  // R3
  read_fill_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_vld_q && !chk_wr_q && chk_miss_q) |->
    (line_state[{chk_idx_q, 1'b0} +: 2] == ST_E || line_state[{chk_idx_q, 1'b0} +: 2] == ST_S));
endmodule

// File: tb/mesi_cache_pair_tb.sv
`timescale 1ns/1ps
module mesi_cache_pair_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_core = 1'b0, req_write = 1'b0;
  logic [5:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic resp_valid, resp_hit;
  logic [7:0] resp_rdata;
  logic [31:0] line_state;

  mesi_cache_pair dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_core(req_core),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_rdata(resp_rdata),
    .line_state(line_state));

  always #5 clk = ~clk;

  int errors = 0, checks = 0;

  int m_st [2][4][2];
  int m_tg [2][4][2];
  bit m_fl [2][4][2];
  logic [7:0] m_d [2][4][2][2];
  int m_lru [2][4];
  logic [7:0] m_mem [64];

  localparam int NV = 24;
  // {core, write, addr[5:0], wdata[7:0]}
  localparam logic [15:0] VEC [NV] = '{
    {1'b0,1'b0,6'd6, 8'h00}, {1'b1,1'b1,6'd7, 8'h21}, {1'b1,1'b0,6'd6, 8'h00},
    {1'b0,1'b1,6'd13,8'h33}, {1'b0,1'b0,6'd22,8'h00}, {1'b0,1'b0,6'd30,8'h00},
    {1'b1,1'b0,6'd12,8'h00}, {1'b0,1'b1,6'd6, 8'h44}, {1'b1,1'b0,6'd7, 8'h00},
    {1'b1,1'b1,6'd1, 8'h55}, {1'b0,1'b0,6'd0, 8'h00}, {1'b0,1'b1,6'd0, 8'h66},
    {1'b1,1'b0,6'd33,8'h00}, {1'b1,1'b0,6'd41,8'h00}, {1'b1,1'b0,6'd1, 8'h00},
    {1'b0,1'b1,6'd49,8'h77}, {1'b0,1'b0,6'd8, 8'h00}, {1'b1,1'b1,6'd48,8'h88},
    {1'b0,1'b0,6'd49,8'h00}, {1'b1,1'b0,6'd13,8'h00}, {1'b0,1'b1,6'd62,8'h99},
    {1'b1,1'b0,6'd63,8'h00}, {1'b0,1'b0,6'd22,8'h00}, {1'b1,1'b1,6'd22,8'hAB}};

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] st_of(input int c, input int s, input int w);
    return line_state[2*(c*8 + s*2 + w) +: 2];
  endfunction

  function automatic logic [31:0] model_vec();
    logic [31:0] v;
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 4; s++)
        for (int w = 0; w < 2; w++)
          v[2*(c*8 + s*2 + w) +: 2] = 2'(m_st[c][s][w]);
    return v;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < 4; s++) begin
        m_lru[c][s] = 0;
        for (int w = 0; w < 2; w++) begin
          m_st[c][s][w] = 0; m_tg[c][s][w] = 0; m_fl[c][s][w] = 0;
          m_d[c][s][w][0] = 0; m_d[c][s][w][1] = 0;
        end
      end
    for (int i = 0; i < 64; i++) m_mem[i] = 8'((7 * i + 1) % 256);
  endtask

  task automatic model_acc(input int c, input bit wr, input int a, input logic [7:0] wd,
                           output bit eh, output logic [7:0] er);
    int s, t, b, o, hw, ow, v;
    bit h, oh, pd;
    logic [7:0] ld [2];
    s = (a >> 1) % 4; t = a >> 3; b = a % 2; o = 1 - c;
    h = 0; hw = 0; oh = 0; ow = 0;
    for (int w = 0; w < 2; w++) begin
      if (m_st[c][s][w] != 0 && m_tg[c][s][w] == t) begin h = 1; hw = w; end
      if (m_st[o][s][w] != 0 && m_tg[o][s][w] == t) begin oh = 1; ow = w; end
    end
    eh = h;
    if (h) begin
      m_lru[c][s] = 1 - hw;
      if (wr) begin
        m_d[c][s][hw][b] = wd; m_st[c][s][hw] = 3;
        if (oh) m_st[o][s][ow] = 0;
        er = wd;
      end else er = m_d[c][s][hw][b];
    end else begin
      if (!m_fl[c][s][0]) v = 0;
      else if (!m_fl[c][s][1]) v = 1;
      else if (m_st[c][s][0] == 0) v = 0;
      else if (m_st[c][s][1] == 0) v = 1;
      else v = m_lru[c][s];
      if (m_st[c][s][v] == 3)
        for (int k = 0; k < 2; k++) m_mem[m_tg[c][s][v]*8 + s*2 + k] = m_d[c][s][v][k];
      pd = oh && m_st[o][s][ow] == 3;
      for (int k = 0; k < 2; k++) ld[k] = pd ? m_d[o][s][ow][k] : m_mem[t*8 + s*2 + k];
      if (pd) for (int k = 0; k < 2; k++) m_mem[t*8 + s*2 + k] = m_d[o][s][ow][k];
      if (oh) m_st[o][s][ow] = wr ? 0 : 1;
      er = wr ? wd : ld[b];
      if (wr) ld[b] = wd;
      for (int k = 0; k < 2; k++) m_d[c][s][v][k] = ld[k];
      m_tg[c][s][v] = t; m_fl[c][s][v] = 1;
      m_st[c][s][v] = wr ? 3 : (oh ? 1 : 2);
      m_lru[c][s] = 1 - v;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  task automatic access(input bit c, input bit wr, input int a, input logic [7:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_core = c; req_write = wr; req_addr = 6'(a); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    bit eh;
    logic [7:0] er;
    do_reset();
    check(line_state == 32'h0, "R1 all lines invalid after reset", line_state, 0);
    check(resp_valid == 1'b0, "R1 no response after reset", 32'(resp_valid), 0);

    for (int i = 0; i < NV; i++) begin
      model_acc(int'(VEC[i][15]), VEC[i][14], int'(VEC[i][13:8]), VEC[i][7:0], eh, er);
      access(VEC[i][15], VEC[i][14], int'(VEC[i][13:8]), VEC[i][7:0]);
      check(resp_valid == 1'b1, "R10 response valid", 32'(resp_valid), 1);
      check(resp_hit == eh, "R2 hit decode", 32'(resp_hit), 32'(eh));
      check(resp_rdata == er, "R10 response data", 32'(resp_rdata), 32'(er));
      check(line_state == model_vec(), "R5 state vector", line_state, model_vec());
    end

    // victim order and LRU
    do_reset();
    access(0, 0, 0, 0);
    check(resp_rdata == 8'h01, "R3 read from memory", 32'(resp_rdata), 32'h01);
    check(st_of(0,0,0) == 2'd2, "R3 sole reader gets E", 32'(st_of(0,0,0)), 2);
    access(1, 1, 0, 8'h11);
    check(st_of(0,0,0) == 2'd0, "R11 peer copy invalidated", 32'(st_of(0,0,0)), 0);
    check(st_of(1,0,0) == 2'd3, "R5 writer in M", 32'(st_of(1,0,0)), 3);
    access(0, 0, 8, 0);
    check(st_of(0,0,1) == 2'd2 && st_of(0,0,0) == 2'd0, "R7 empty way before invalid",
          32'({st_of(0,0,1), st_of(0,0,0)}), 32'h8);
    access(0, 0, 16, 0);
    check(st_of(0,0,0) == 2'd2 && resp_rdata == 8'h71, "R7 invalid way reused",
          32'({st_of(0,0,0), resp_rdata}), 32'h271);
    access(0, 0, 9, 0);
    check(resp_hit == 1'b1 && resp_rdata == 8'h40, "R9 hit on way1",
          32'({resp_hit, resp_rdata}), 32'h140);
    access(0, 0, 24, 0);
    check(resp_hit == 1'b0 && resp_rdata == 8'hA9, "R7 LRU fill", 32'({resp_hit, resp_rdata}), 32'h0A9);
    access(0, 0, 8, 0);
    check(resp_hit == 1'b1, "R9 hit refreshed recency", 32'(resp_hit), 1);

    // dual write-back in one cycle, silent upgrade
    do_reset();
    access(0, 1, 2, 8'hAA);
    check(resp_rdata == 8'hAA && st_of(0,1,0) == 2'd3, "R10 write echo and M",
          32'({st_of(0,1,0), resp_rdata}), 32'h3AA);
    access(0, 1, 10, 8'hBB);
    access(1, 1, 19, 8'hCC);
    access(0, 0, 19, 0);
    check(resp_hit == 1'b0 && resp_rdata == 8'hCC, "R4 peer supplies dirty byte",
          32'({resp_hit, resp_rdata}), 32'h0CC);
    check(st_of(0,1,0) == 2'd1 && st_of(1,1,0) == 2'd1, "R4 both shared",
          32'({st_of(0,1,0), st_of(1,1,0)}), 32'h5);
    access(1, 0, 2, 0);
    check(resp_rdata == 8'hAA && st_of(1,1,1) == 2'd2, "R8 evicted dirty line in memory",
          32'({st_of(1,1,1), resp_rdata}), 32'h2AA);
    access(1, 1, 3, 8'hDD);
    check(resp_hit == 1'b1 && st_of(1,1,1) == 2'd3, "R6 E upgraded to M",
          32'({resp_hit, st_of(1,1,1)}), 32'h7);
    check(st_of(0,1,0) == 2'd1 && st_of(0,1,1) == 2'd3 && st_of(1,1,0) == 2'd1,
          "R6 peer untouched", 32'({st_of(0,1,0), st_of(0,1,1), st_of(1,1,0)}), 32'h1D);
    access(0, 1, 18, 8'hEE);
    check(st_of(0,1,0) == 2'd3 && st_of(1,1,0) == 2'd0, "R5 shared write invalidates peer",
          32'({st_of(0,1,0), st_of(1,1,0)}), 32'hC);

    summary();
    $finish;
  end
endmodule